// File: doc/BRIEF.md
# Cassette Transport Controller with Serial Read Capture

This block sits between a host and a digital cassette drive. The host issues a three-bit command that asks for forward or reverse motion, with or without fast wind, or for a stop. The block turns that command into three registered motor lines. The decode can never raise both direction lines together. The block also stops the motor by itself when the cassette goes away or when the leader comes into view.

On the read side the drive supplies its own read clock. That clock speeds up as the take-up spool fills, so the block keeps no bit timer. It resynchronises the read clock and read data and takes one bit on each rising edge of the resynchronised clock, most significant bit first. Each group of eight bits becomes a byte for the host. A byte-ready pulse marks each new byte, an available flag stays up until the host acknowledges the byte, and a sticky overrun flag records a byte that arrived before the previous one was taken.

Two status outputs give the resynchronised cassette-present and leader-visible levels.

Top module: `tape_xport_ctrl`

## Requirements
- R1: `mot_fwd_o` and `mot_rev_o` are never high in the same cycle.
- R2: A command is taken when `cmd_valid_i` is high. `cmd_i[0]` requests forward, `cmd_i[1]` requests reverse and `cmd_i[2]` requests fast. One direction alone gives that direction at normal speed. One direction with fast also raises `mot_fast_o`. The motor outputs change one clock after the command is sampled.
- R3: A command that requests both forward and reverse drives all motor outputs low, whatever the fast bit is.
- R4: A command that requests fast without any direction drives all motor outputs low.
- R5: When the synchronised tape sense is low, all motor outputs are driven low. A command accepted in that state leaves the motor stopped.
- R6: A synchronised rising edge of the leader input while the motor runs stops the motor, and this wins over a command in the same cycle. While the leader stays high, a new command is obeyed, so the tape can be moved off the leader.
- R7: `present_o` and `at_leader_o` follow `tape_sense_i` and `leader_i` two clocks later, and are low after reset.
- R8: Read data is sampled only on the synchronised rising edge of `rd_clk_i`, and bits are assembled MSB first. Each high phase and each low phase of the read clock must last at least two clocks. No fixed bit period is assumed, so the gaps between edges may shrink during a byte.
- R9: `byte_rdy_o` is high for exactly one clock after each eighth bit. In that clock `byte_o` presents the new byte, and `byte_o` holds it until the next byte completes.
- R10: `byte_avail_o` rises when a byte completes and falls on `byte_ack_i`. `overrun_o` is set when a byte completes while `byte_avail_o` is high with no acknowledge in that cycle, and `byte_ack_i` clears it. When a byte completes in the same cycle as an acknowledge, `byte_avail_o` stays high and `overrun_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | {fast, reverse, forward} request |
| tape_sense_i | input | 1 | High when a cassette is inserted and the lid is closed (asynchronous) |
| leader_i | input | 1 | High when the transparent leader is in view (asynchronous) |
| rd_clk_i | input | 1 | Read clock from the drive (asynchronous) |
| rd_data_i | input | 1 | Read data from the drive (asynchronous) |
| byte_ack_i | input | 1 | Host takes the current byte |
| mot_fwd_o | output | 1 | Forward motor line |
| mot_rev_o | output | 1 | Reverse motor line |
| mot_fast_o | output | 1 | Fast wind line |
| present_o | output | 1 | Synchronised cassette-present status |
| at_leader_o | output | 1 | Synchronised leader status |
| byte_o | output | 8 | Last assembled byte |
| byte_rdy_o | output | 1 | One-clock pulse per new byte |
| byte_avail_o | output | 1 | Unacknowledged byte held |
| overrun_o | output | 1 | Sticky lost-byte flag |

## Verification
Two pairs of functions can fall in the same clock. In the first pair, a byte completes in the same clock as the host acknowledge of the previous byte. The bench provokes this by raising the acknowledge two clocks after the final read-clock rise, so that it lands in the capture cycle; the available flag must then stay high with no overrun. In the second pair, a leader rising edge meets a host command. The bench-side model applies the leader stop ahead of the command, and that model is compared against the motor lines on every clock.

// File: rtl/tape_xport_pkg.sv
package tape_xport_pkg;

    localparam int CMD_W = 3;
    localparam int CMD_FWD_BIT  = 0;
    localparam int CMD_REV_BIT  = 1;
    localparam int CMD_FAST_BIT = 2;

    typedef struct packed {
        logic fwd;
        logic rev;
        logic fast;
    } motor_t;

    localparam motor_t MOTOR_IDLE = '{fwd: 1'b0, rev: 1'b0, fast: 1'b0};

endpackage

// File: rtl/tape_xport_sync.sv
module tape_xport_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], async_i[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sync_o[b] = chain_q[LAST];
        end
    endgenerate
endmodule

// File: rtl/tape_xport_motor.sv
module tape_xport_motor
    import tape_xport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             sense_s_i,
    input  logic             leader_s_i,
    output motor_t           motor_o
);
    typedef struct packed {
        motor_t mot;
        logic   leader_prev;
    } mstate_t;

    mstate_t st_d, st_q;
    motor_t  decoded;
    logic    leader_rise;
    logic    moving;

    always_comb begin
        decoded = MOTOR_IDLE;
        if (cmd_i[CMD_FWD_BIT] ^ cmd_i[CMD_REV_BIT]) begin
            decoded.fwd  = cmd_i[CMD_FWD_BIT];
            decoded.rev  = cmd_i[CMD_REV_BIT];
            decoded.fast = cmd_i[CMD_FAST_BIT];
        end
    end

    always_comb begin
        leader_rise = leader_s_i & ~st_q.leader_prev;
        moving      = st_q.mot.fwd | st_q.mot.rev;
        st_d             = st_q;
        st_d.leader_prev = leader_s_i;
        if (!sense_s_i) begin
            st_d.mot = MOTOR_IDLE;
        end else if (leader_rise && moving) begin
            st_d.mot = MOTOR_IDLE;
        end else if (cmd_valid_i) begin
            st_d.mot = decoded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mot: MOTOR_IDLE, leader_prev: 1'b0};
        else        st_q <= st_d;
    end

    assign motor_o = st_q.mot;

    p_dir_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_o.fwd && motor_o.rev));

    p_fast_needs_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        motor_o.fast |-> (motor_o.fwd || motor_o.rev));

    p_sense_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_s_i |=> (motor_o == MOTOR_IDLE));

    p_leader_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (leader_rise && (motor_o.fwd || motor_o.rev)) |=> (motor_o == MOTOR_IDLE));
endmodule

// File: rtl/tape_xport_capture.sv
module tape_xport_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rclk_s_i,
    input  logic              rdata_s_i,
    input  logic              ack_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              rdy_o,
    output logic              avail_o,
    output logic              ovr_o
);
    localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] data;
        logic              rclk_prev;
        logic              rdy;
        logic              avail;
        logic              ovr;
    } cstate_t;

    cstate_t st_d, st_q;
    logic    bit_edge;
    logic    done;
    logic [BYTE_W-1:0] next_sh;

    always_comb begin
        bit_edge = rclk_s_i & ~st_q.rclk_prev;
        next_sh  = {st_q.shreg[BYTE_W-2:0], rdata_s_i};
        done     = bit_edge && (st_q.cnt == LAST_BIT);

        st_d           = st_q;
        st_d.rclk_prev = rclk_s_i;
        st_d.rdy       = done;
        if (bit_edge) begin
            st_d.shreg = next_sh;
            st_d.cnt   = done ? '0 : st_q.cnt + 1'b1;
        end
        if (done) begin
            st_d.data  = next_sh;
            st_d.avail = 1'b1;
            if (st_q.avail && !ack_i) st_d.ovr = 1'b1;
            else if (ack_i)           st_d.ovr = 1'b0;
        end else if (ack_i) begin
            st_d.avail = 1'b0;
            st_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o  = st_q.data;
    assign rdy_o   = st_q.rdy;
    assign avail_o = st_q.avail;
    assign ovr_o   = st_q.ovr;

    p_rdy_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);

    p_rdy_avail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> avail_o);

    p_ovr_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> rdy_o);

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_o |-> $stable(byte_o));
endmodule

// File: rtl/tape_xport_ctrl.sv
module tape_xport_ctrl
    import tape_xport_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_i,
    input  logic              tape_sense_i,
    input  logic              leader_i,
    input  logic              rd_clk_i,
    input  logic              rd_data_i,
    input  logic              byte_ack_i,
    output logic              mot_fwd_o,
    output logic              mot_rev_o,
    output logic              mot_fast_o,
    output logic              present_o,
    output logic              at_leader_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_rdy_o,
    output logic              byte_avail_o,
    output logic              overrun_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] synced;
    motor_t           motor;

    assign raw_in = {rd_data_i, rd_clk_i, leader_i, tape_sense_i};

    tape_xport_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    tape_xport_motor u_motor (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_i),
        .sense_s_i   (synced[0]),
        .leader_s_i  (synced[1]),
        .motor_o     (motor)
    );

    tape_xport_capture #(.BYTE_W(BYTE_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rclk_s_i  (synced[2]),
        .rdata_s_i (synced[3]),
        .ack_i     (byte_ack_i),
        .byte_o    (byte_o),
        .rdy_o     (byte_rdy_o),
        .avail_o   (byte_avail_o),
        .ovr_o     (overrun_o)
    );

    assign mot_fwd_o   = motor.fwd;
    assign mot_rev_o   = motor.rev;
    assign mot_fast_o  = motor.fast;
    assign present_o   = synced[0];
    assign at_leader_o = synced[1];

    p_status_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (present_o == 1'b0) |-> !(mot_fwd_o || mot_rev_o) || $past(present_o));
endmodule

// File: tb/tape_xport_ctrl_tb.sv
module tape_xport_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [2:0] cmd_i = 3'b000;
    logic       tape_sense_i = 1'b0;
    logic       leader_i = 1'b0;
    logic       rd_clk_i = 1'b0;
    logic       rd_data_i = 1'b0;
    logic       byte_ack_i = 1'b0;
    logic       mot_fwd_o, mot_rev_o, mot_fast_o;
    logic       present_o, at_leader_o;
    logic [7:0] byte_o;
    logic       byte_rdy_o, byte_avail_o, overrun_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tape_xport_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
        .tape_sense_i(tape_sense_i), .leader_i(leader_i), .rd_clk_i(rd_clk_i),
        .rd_data_i(rd_data_i), .byte_ack_i(byte_ack_i), .mot_fwd_o(mot_fwd_o),
        .mot_rev_o(mot_rev_o), .mot_fast_o(mot_fast_o), .present_o(present_o),
        .at_leader_o(at_leader_o), .byte_o(byte_o), .byte_rdy_o(byte_rdy_o),
        .byte_avail_o(byte_avail_o), .overrun_o(overrun_o)
    );

    // Reference model: input history (index 0 = newest sample).
    int hs[4], hl[4], hc[4], hd[4];
    int m_fwd, m_rev, m_fast;
    int r_sh, r_cnt, r_data, r_rdy, r_avail, r_ovr;
    int e_present, e_leader;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                hs[i] = 0; hl[i] = 0; hc[i] = 0; hd[i] = 0;
            end
            m_fwd = 0; m_rev = 0; m_fast = 0;
            r_sh = 0; r_cnt = 0; r_data = 0; r_rdy = 0; r_avail = 0; r_ovr = 0;
            e_present = 0; e_leader = 0;
        end else begin
            int f, r, fa, done;
            for (int i = 3; i > 0; i--) begin
                hs[i] = hs[i-1]; hl[i] = hl[i-1]; hc[i] = hc[i-1]; hd[i] = hd[i-1];
            end
            hs[0] = tape_sense_i; hl[0] = leader_i; hc[0] = rd_clk_i; hd[0] = rd_data_i;
            // motor (R2..R6)
            if (hs[2] == 0) begin
                m_fwd = 0; m_rev = 0; m_fast = 0;
            end else if (hl[2] == 1 && hl[3] == 0 && (m_fwd || m_rev)) begin
                m_fwd = 0; m_rev = 0; m_fast = 0;
            end else if (cmd_valid_i) begin
                f = cmd_i[0]; r = cmd_i[1]; fa = cmd_i[2];
                if (f != r) begin m_fwd = f; m_rev = r; m_fast = fa; end
                else begin m_fwd = 0; m_rev = 0; m_fast = 0; end
            end
            // capture (R8..R10)
            done = 0;
            if (hc[2] == 1 && hc[3] == 0) begin
                r_sh = ((r_sh << 1) | hd[2]) & 255;
                r_cnt++;
                if (r_cnt == 8) begin r_cnt = 0; done = 1; end
            end
            if (done) begin
                r_data = r_sh;
                if (r_avail && !byte_ack_i) r_ovr = 1;
                else if (byte_ack_i) r_ovr = 0;
                r_avail = 1;
            end else if (byte_ack_i) begin
                r_avail = 0; r_ovr = 0;
            end
            r_rdy = done;
            e_present = hs[1]; e_leader = hl[1];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 dir exclusive", int'(mot_fwd_o & mot_rev_o), 0);
            chk("R2 fwd line", mot_fwd_o, m_fwd);
            chk("R2 rev line", mot_rev_o, m_rev);
            chk("R2 fast line", mot_fast_o, m_fast);
            chk("R7 present", present_o, e_present);
            chk("R7 leader", at_leader_o, e_leader);
            chk("R9 rdy", byte_rdy_o, r_rdy);
            chk("R9 byte", byte_o, r_data);
            chk("R10 avail", byte_avail_o, r_avail);
            chk("R10 overrun", overrun_o, r_ovr);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] c);
        @(negedge clk);
        cmd_i = c; cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cyc(2);
    endtask

    task automatic send_byte(input logic [7:0] b, input int hp0, input bit ack_last);
        int hp;
        hp = hp0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            rd_data_i = b[i];
            cyc(hp);
            rd_clk_i = 1'b1;
            if (i == 0 && ack_last) begin
                @(posedge clk); @(posedge clk);
                @(negedge clk); byte_ack_i = 1'b1;
                @(negedge clk); byte_ack_i = 1'b0;
            end else begin
                cyc(hp);
            end
            rd_clk_i = 1'b0;
            if (hp > 2 && i % 2 == 0) hp--;
        end
        cyc(hp + 4);
    endtask

    task automatic ack();
        @(negedge clk); byte_ack_i = 1'b1;
        @(negedge clk); byte_ack_i = 1'b0;
        cyc(1);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R7 reset present", present_o, 0);
        chk("R2 reset motor", {mot_fwd_o, mot_rev_o, mot_fast_o}, 0);
        chk("R10 reset avail", byte_avail_o, 0);
        rst_n = 1'b1;
        cyc(2);
        cmd(3'b001);
        chk("R5 cmd refused without cassette", mot_fwd_o, 0);
        tape_sense_i = 1'b1;
        cyc(4);
        chk("R7 present high", present_o, 1);
        cmd(3'b001);
        chk("R2 forward normal", {mot_fast_o, mot_rev_o, mot_fwd_o}, 3'b001);
        cmd(3'b101);
        chk("R2 forward fast", {mot_fast_o, mot_rev_o, mot_fwd_o}, 3'b101);
        cmd(3'b110);
        chk("R2 reverse fast", {mot_fast_o, mot_rev_o, mot_fwd_o}, 3'b110);
        cmd(3'b011);
        chk("R3 both dirs stop", {mot_fast_o, mot_rev_o, mot_fwd_o}, 3'b000);
        cmd(3'b010);
        cmd(3'b100);
        chk("R4 fast alone stop", {mot_fast_o, mot_rev_o, mot_fwd_o}, 3'b000);
        cmd(3'b001);
        leader_i = 1'b1;
        cyc(4);
        chk("R6 leader stops", mot_fwd_o, 0);
        cmd(3'b010);
        chk("R6 move off leader", mot_rev_o, 1);
        leader_i = 1'b0;
        cyc(3);
        // leader edge meets command in the same cycle
        cmd(3'b001);
        @(negedge clk); leader_i = 1'b1;
        @(negedge clk);
        @(negedge clk); cmd_i = 3'b101; cmd_valid_i = 1'b1;
        @(negedge clk); cmd_valid_i = 1'b0;
        cyc(2);
        chk("R6 leader wins over command", mot_fwd_o, 0);
        leader_i = 1'b0;
        cyc(3);
        cmd(3'b001);
        tape_sense_i = 1'b0;
        cyc(4);
        chk("R5 cassette removed stops", mot_fwd_o, 0);
        tape_sense_i = 1'b1;
        cyc(4);
        // capture with shrinking bit period
        send_byte(8'hA5, 6, 0);
        chk("R8 first byte msb first", byte_o, 8'hA5);
        chk("R10 avail set", byte_avail_o, 1);
        ack();
        chk("R10 ack clears avail", byte_avail_o, 0);
        send_byte(8'h3C, 4, 0);
        send_byte(8'hFF, 2, 0);
        chk("R10 overrun set", overrun_o, 1);
        chk("R9 latest byte", byte_o, 8'hFF);
        ack();
        chk("R10 ack clears overrun", overrun_o, 0);
        send_byte(8'h81, 3, 0);
        send_byte(8'h5E, 3, 1);
        chk("R10 same-cycle ack keeps avail", byte_avail_o, 1);
        chk("R10 same-cycle ack no overrun", overrun_o, 0);
        chk("R8 byte after collision", byte_o, 8'h5E);
        // data toggling with no clock edge is not sampled
        rd_data_i = 1'b1; cyc(10); rd_data_i = 1'b0; cyc(10);
        chk("R8 no edge no capture", byte_o, 8'h5E);
        cyc(5);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule